// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column addresses of a synchronous DRAM burst, one per clock. It sits in a memory controller, between the command scheduler and the address pins. It keeps a copy of the 12-bit mode word that the controller programs into the memory. When a read or write command is issued, it steps through the columns in the order the memory itself will use. The controller can then tag data beats, drive write data and find the final beat without decoding the burst rules itself.

The mode word sets four things: the burst length (1, 2, 4, 8 or a whole 512-column row), the wrap order (sequential or interleaved), the read latency, and a write override that limits writes to one location. A load whose length or latency code is not supported, or that asks for an interleaved whole-row burst, is rejected. A rejected load raises an error flag and leaves the working settings as they were. A burst captures its settings when it starts. It can be cut short by a terminate input or replaced by a new start.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset the settings are burst length 1, sequential order and read latency 2. `mode_err` and `col_valid` are low.
- R2: A `start` sampled at a clock edge makes `col_valid` high from that edge onward. The first beat presents `start_col`, and each later clock presents the next beat.
- R3: Mode bits [2:0] set the length: 000=1, 001=2, 010=4, 011=8, 111=whole row. For a length of 2, 4 or 8 with bit [3]=0, beat k presents the column whose low bits are (start low bits + k) modulo the length. The upper bits keep the start's aligned block.
- R4: With bit [3]=1 and a length of 2, 4 or 8, beat k presents the start column's low bits XORed with k. The upper bits keep the start's aligned block.
- R5: A whole-row burst presents start_col+k modulo 512. It never raises `col_last` and continues until it is terminated.
- R6: With a length of 1, bit [3] has no effect. Exactly one beat presents `start_col`, and it carries `col_last`.
- R7: `col_last` is high only on the final beat of a fixed-length burst. On the clock after that beat, `col_valid` falls unless a new `start` is present.
- R8: `terminate` sampled high during a burst, without `start`, makes `col_valid` low on the next clock.
- R9: Mode bits [6:4] set the read latency: 010 gives 2 and 011 gives 3. The value appears on `cas_latency` as 2'd2 or 2'd3.
- R10: When mode bit [9] is 1, a burst started with `is_write`=1 is one beat long. A burst with `is_write`=0 still uses the programmed length.
- R11: A load whose length code is 100–110, whose latency code is not 010 or 011, or that combines bit [3]=1 with length 111, sets `mode_err` and changes no setting. A legal load applies its settings and clears `mode_err`.
- R12: A `start` during a burst abandons it. The new burst begins at the new column on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_data | input | 12 | Mode word operand |
| start | input | 1 | Begin a burst |
| start_col | input | 9 | First column of the burst |
| is_write | input | 1 | 1 = write command, 0 = read |
| terminate | input | 1 | End the running burst |
| col_out | output | 9 | Column for the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the final beat |
| cas_latency | output | 2 | Programmed read latency (2 or 3) |
| mode_err | output | 1 | Last mode load was rejected |

## Verification
The bench starts bursts whose offset is not zero inside the block, so the wrap point matters. A sequencer that carried into the upper bits would leave the block, and one that used addition where XOR is needed would give the wrong interleaved order. A whole-row burst is started two columns below the top of the row, to catch a missing modulo-512 wrap or a stray `col_last`. Rejected loads are followed by a burst and a latency readback, so a design that partly applied a bad word would show it. The write override is checked on a write and then on a read, and the burst is cut mid-way both by `terminate` and by a new `start`.

// File: rtl/colseq_pkg.sv
// Package colseq_pkg
// Shared field layout and code values for the column sequencer's mode word.
// Assumes a 12-bit mode word whose field positions are fixed by the memory.
package colseq_pkg;

    localparam int MODE_W = 12;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_ROW  = 3'b111;

    localparam logic [2:0] LAT_2    = 3'b010;
    localparam logic [2:0] LAT_3    = 3'b011;

    typedef struct packed {
        logic       wr_single;
        logic [2:0] lat_code;
        logic       interleave;
        logic [2:0] len_code;
    } mode_cfg_t;

    localparam mode_cfg_t CFG_RESET = '{wr_single: 1'b0, lat_code: LAT_2,
                                        interleave: 1'b0, len_code: LEN_1};

    // Pull the used fields out of a raw mode word.
    function automatic mode_cfg_t unpack_mode(input logic [MODE_W-1:0] w);
        mode_cfg_t c;
        c.len_code   = w[2:0];
        c.interleave = w[3];
        c.lat_code   = w[6:4];
        c.wr_single  = w[9];
        return c;
    endfunction

    // True when every field of a candidate setting is supported.
    function automatic logic cfg_legal(input mode_cfg_t c);
        logic len_ok;
        logic lat_ok;
        len_ok = (c.len_code == LEN_1) || (c.len_code == LEN_2) ||
                 (c.len_code == LEN_4) || (c.len_code == LEN_8) ||
                 (c.len_code == LEN_ROW);
        lat_ok = (c.lat_code == LAT_2) || (c.lat_code == LAT_3);
        return len_ok && lat_ok && !(c.interleave && (c.len_code == LEN_ROW));
    endfunction

endpackage

// File: rtl/colseq_mode_reg.sv
// Module colseq_mode_reg
// Holds the working burst settings. It accepts a mode word only when all of
// its fields are legal. Otherwise it flags an error and keeps what it had.
// Assumes the load strobe is one clock wide per word.
module colseq_mode_reg
    import colseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              err
);

    mode_cfg_t cand;
    logic      cand_ok;

    // Decode the incoming word and judge its legality.
    always_comb begin
        cand    = unpack_mode(word);
        cand_ok = cfg_legal(cand);
    end

    // Update the settings on a legal load, record rejection otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (load) begin
            if (cand_ok) begin
                cfg <= cand;
                err <= 1'b0;
            end else begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/colseq_beat_ctrl.sv
// Module colseq_beat_ctrl
// Runs one burst: it captures the start column and the burst shape when the
// burst starts, then counts beats until the last one, a terminate or a
// restart. Assumes COL_W >= 3 so that a block of eight fits in a row.
module colseq_beat_ctrl
    import colseq_pkg::*;
#(
    parameter int COL_W = 9
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             is_write,
    input  logic             terminate,
    input  mode_cfg_t        cfg,
    output logic             active,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] base_col,
    output logic [COL_W-1:0] wrap_mask,
    output logic             use_xor,
    output logic             is_last
);

    logic [2:0]       eff_len;
    logic [COL_W-1:0] next_mask;
    logic             row_mode;

    // Apply the single-location write override to the length code.
    always_comb begin
        eff_len = (is_write && cfg.wr_single) ? LEN_1 : cfg.len_code;
    end

    // Turn the length code into the mask of column bits that wrap.
    always_comb begin
        case (eff_len)
            LEN_2:   next_mask = COL_W'(1);
            LEN_4:   next_mask = COL_W'(3);
            LEN_8:   next_mask = COL_W'(7);
            LEN_ROW: next_mask = '1;
            default: next_mask = '0;
        endcase
    end

    // Capture the burst shape and advance the beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            beat_idx  <= '0;
            base_col  <= '0;
            wrap_mask <= '0;
            use_xor   <= 1'b0;
            row_mode  <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            beat_idx  <= '0;
            base_col  <= start_col;
            wrap_mask <= next_mask;
            use_xor   <= cfg.interleave && (eff_len != LEN_1);
            row_mode  <= (eff_len == LEN_ROW);
        end else if (active && (terminate || is_last)) begin
            active    <= 1'b0;
        end else if (active) begin
            beat_idx  <= beat_idx + COL_W'(1);
        end
    end

    // Flag the final beat of a fixed-length burst.
    always_comb begin
        is_last = active && !row_mode && (beat_idx == wrap_mask);
    end

endmodule

// File: rtl/colseq_addr_gen.sv
// Module colseq_addr_gen
// Combines the start column with the beat index to form the current column.
// The masked low bits wrap by addition or by XOR, and the unmasked high bits
// come from the start column unchanged. Assumes a mask of contiguous low ones.
module colseq_addr_gen #(
    parameter int COL_W = 9
)(
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             use_xor,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] offset;

    // Form the wrapped offset and merge it with the fixed block bits.
    always_comb begin
        offset = use_xor ? (base_col ^ beat_idx) : (base_col + beat_idx);
        col    = (base_col & ~wrap_mask) | (offset & wrap_mask);
    end

endmodule

// File: rtl/sdram_col_seq.sv
// Module sdram_col_seq
// Top of the burst column sequencer: the mode register, the beat controller
// and the column generator. Outputs come straight from registered state, so
// the first beat appears on the clock after start.
module sdram_col_seq
    import colseq_pkg::*;
#(
    parameter int COL_W = 9
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              is_write,
    input  logic              terminate,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        cas_latency,
    output logic              mode_err
);

    mode_cfg_t        cfg;
    logic             active;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] base_col;
    logic [COL_W-1:0] wrap_mask;
    logic             use_xor;
    logic             is_last;

    colseq_mode_reg mode_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .word  (mode_data),
        .cfg   (cfg),
        .err   (mode_err)
    );

    colseq_beat_ctrl #(.COL_W(COL_W)) beat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .is_write  (is_write),
        .terminate (terminate),
        .cfg       (cfg),
        .active    (active),
        .beat_idx  (beat_idx),
        .base_col  (base_col),
        .wrap_mask (wrap_mask),
        .use_xor   (use_xor),
        .is_last   (is_last)
    );

    colseq_addr_gen #(.COL_W(COL_W)) addr_i (
        .base_col  (base_col),
        .beat_idx  (beat_idx),
        .wrap_mask (wrap_mask),
        .use_xor   (use_xor),
        .col       (col_out)
    );

    // Drive the beat flags and the latency value from internal state.
    always_comb begin
        col_valid   = active;
        col_last    = is_last;
        cas_latency = cfg.lat_code[1:0];
    end

endmodule

// File: rtl/colseq_chk.sv
// Module colseq_chk
// Port-level protocol checks for sdram_col_seq, attached with bind below.
module colseq_chk #(
    parameter int COL_W = 9
)(
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic [11:0]      mode_data,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             terminate,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last,
    input logic [1:0]       cas_latency,
    input logic             mode_err
);

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_out == $past(start_col)));

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R7
    stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_last && !start) |=> !col_valid);

    // R8
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && terminate && !start) |=> !col_valid);

    // R11
    bad_lat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && mode_data[6:4] != 3'b010 && mode_data[6:4] != 3'b011)
        |=> (mode_err && cas_latency == $past(cas_latency)));

endmodule

bind sdram_col_seq colseq_chk #(.COL_W(COL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_load   (mode_load),
    .mode_data   (mode_data),
    .start       (start),
    .start_col   (start_col),
    .terminate   (terminate),
    .col_out     (col_out),
    .col_valid   (col_valid),
    .col_last    (col_last),
    .cas_latency (cas_latency),
    .mode_err    (mode_err)
);

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [11:0] mode_data = '0;
    logic        start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        is_write = 1'b0;
    logic        terminate = 1'b0;
    logic [8:0]  col_out;
    logic        col_valid;
    logic        col_last;
    logic [1:0]  cas_latency;
    logic        mode_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_col_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_data(mode_data),
        .start(start), .start_col(start_col), .is_write(is_write),
        .terminate(terminate), .col_out(col_out), .col_valid(col_valid),
        .col_last(col_last), .cas_latency(cas_latency), .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic [2:0] len, input logic itl,
                                       input logic [2:0] lat, input logic wsingle);
        return {2'b00, wsingle, 2'b00, lat, itl, len};
    endfunction

    // Expected column of beat k; len 0 means a whole row.
    function automatic logic [8:0] model(input logic [8:0] s, input int k,
                                         input int len, input bit itl);
        logic [8:0] m;
        logic [8:0] off;
        if (len == 0) return 9'(s + 9'(k));
        m   = 9'(len - 1);
        off = itl ? (s ^ 9'(k)) : 9'(s + 9'(k));
        return (s & ~m) | (off & m);
    endfunction

    task automatic load_mode(input logic [11:0] w);
        @(negedge clk); mode_load = 1'b1; mode_data = w;
        @(negedge clk); mode_load = 1'b0;
    endtask

    task automatic burst(input logic [8:0] c, input bit wr, input int len,
                         input bit itl, input string req);
        @(negedge clk); start = 1'b1; start_col = c; is_write = wr;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < len; k++) begin
            chk(col_valid, req, "valid", col_valid, 1);
            chk(col_out == model(c, k, len, itl), req, "col", col_out, model(c, k, len, itl));
            chk(col_last == (k == len - 1), req, "last", col_last, (k == len - 1));
            @(negedge clk);
        end
        chk(!col_valid, req, "idle after burst", col_valid, 0);
    endtask

    task automatic t_reset();
        chk(!col_valid, "R1", "valid at reset", col_valid, 0);
        chk(!mode_err, "R1", "err at reset", mode_err, 0);
        chk(cas_latency == 2'd2, "R1", "latency at reset", cas_latency, 2);
        burst(9'h1A3, 1'b0, 1, 1'b0, "R1");
    endtask

    task automatic t_seq();
        load_mode(mk(3'b010, 1'b0, 3'b011, 1'b0));
        chk(cas_latency == 2'd3, "R9", "latency 3", cas_latency, 3);
        burst(9'h006, 1'b0, 4, 1'b0, "R3");
        load_mode(mk(3'b011, 1'b0, 3'b010, 1'b0));
        chk(cas_latency == 2'd2, "R9", "latency 2", cas_latency, 2);
        burst(9'h00D, 1'b0, 8, 1'b0, "R3");
        load_mode(mk(3'b001, 1'b0, 3'b010, 1'b0));
        burst(9'h1FF, 1'b0, 2, 1'b0, "R3");
    endtask

    task automatic t_itl();
        load_mode(mk(3'b011, 1'b1, 3'b010, 1'b0));
        burst(9'h045, 1'b0, 8, 1'b1, "R4");
        load_mode(mk(3'b010, 1'b1, 3'b010, 1'b0));
        burst(9'h01E, 1'b0, 4, 1'b1, "R4");
        load_mode(mk(3'b000, 1'b1, 3'b010, 1'b0));
        burst(9'h077, 1'b0, 1, 1'b0, "R6");
    endtask

    task automatic t_row();
        load_mode(mk(3'b111, 1'b0, 3'b010, 1'b0));
        @(negedge clk); start = 1'b1; start_col = 9'd510; is_write = 1'b0;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk(col_valid, "R5", "row valid", col_valid, 1);
            chk(col_out == model(9'd510, k, 0, 1'b0), "R5", "row col", col_out, model(9'd510, k, 0, 1'b0));
            chk(!col_last, "R5", "row no last", col_last, 0);
            if (k == 5) terminate = 1'b1;
            @(negedge clk);
        end
        terminate = 1'b0;
        chk(!col_valid, "R8", "row stopped", col_valid, 0);
    endtask

    task automatic t_term();
        load_mode(mk(3'b011, 1'b0, 3'b010, 1'b0));
        @(negedge clk); start = 1'b1; start_col = 9'h100;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(col_out == 9'h101 && col_valid, "R8", "beat before cut", col_out, 9'h101);
        terminate = 1'b1;
        @(negedge clk); terminate = 1'b0;
        chk(!col_valid, "R8", "cut next clock", col_valid, 0);
    endtask

    task automatic t_restart();
        @(negedge clk); start = 1'b1; start_col = 9'h000;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(col_out == 9'h001, "R12", "first burst beat", col_out, 1);
        start = 1'b1; start_col = 9'h033;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk(col_valid && col_out == model(9'h033, k, 8, 1'b0), "R12", "restart col",
                col_out, model(9'h033, k, 8, 1'b0));
            chk(col_last == (k == 7), "R12", "restart last", col_last, (k == 7));
            @(negedge clk);
        end
        chk(!col_valid, "R12", "idle after restart", col_valid, 0);
    endtask

    task automatic t_write_single();
        load_mode(mk(3'b010, 1'b0, 3'b011, 1'b1));
        burst(9'h021, 1'b1, 1, 1'b0, "R10");
        burst(9'h021, 1'b0, 4, 1'b0, "R10");
        load_mode(mk(3'b010, 1'b0, 3'b011, 1'b0));
        burst(9'h021, 1'b1, 4, 1'b0, "R10");
    endtask

    task automatic t_reserved();
        load_mode(mk(3'b101, 1'b0, 3'b010, 1'b0));
        chk(mode_err, "R11", "bad length err", mode_err, 1);
        chk(cas_latency == 2'd3, "R11", "latency kept", cas_latency, 3);
        burst(9'h005, 1'b0, 4, 1'b0, "R11");
        load_mode(mk(3'b011, 1'b0, 3'b001, 1'b0));
        chk(mode_err, "R11", "bad latency err", mode_err, 1);
        chk(cas_latency == 2'd3, "R11", "latency kept 2", cas_latency, 3);
        load_mode(mk(3'b111, 1'b1, 3'b010, 1'b0));
        chk(mode_err, "R11", "itl row err", mode_err, 1);
        burst(9'h00E, 1'b0, 4, 1'b0, "R11");
        load_mode(mk(3'b001, 1'b0, 3'b010, 1'b0));
        chk(!mode_err, "R11", "err cleared", mode_err, 0);
        chk(cas_latency == 2'd2, "R11", "new latency", cas_latency, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_itl();
        t_row();
        t_term();
        t_restart();
        t_write_single();
        t_reserved();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule